// File: doc/BRIEF.md
# Calendar Clock Register File

This block keeps calendar time (seconds, minutes, hours, day of month, month, year within century, century and a day-of-week count) as packed BCD bytes in a small byte-addressed register bank. A fast enable pulse `tick` drives a prescaler. Every `TICKS_PER_SEC` pulses the seconds field advances, and carries ripple up through the calendar. The ripple follows month lengths and leap years, and it understands both a 24-hour and a 12-hour-with-PM hour encoding.

Software reaches the bank through single-cycle write strobes and combinational reads on an 8-bit data path. A status byte holds a two-stage write-enable latch. Time and control bytes accept writes only while both stages are set, so a stray store cannot corrupt the clock. The same status byte also shows live battery and oscillator-failure flags that come from outside.

Top module: `rtc_regbank`

## Requirements
- R1: After reset: seconds 0x00, minutes 0x00, hour 0x80 (24-hour mode, hour 0), date 0x01, month 0x01, year 0x00, day of week 0x00, century 0x20, control 0x00, both enable bits clear.
- R2: Reads are combinational. Time bytes sit at 0x30..0x37 in the order seconds, minutes, hour, date, month, year, day of week, century; control sits at 0x10 and status at 0x3F. Any other address reads 0x00, and `rdata` is 0x00 whenever `rd_en` is low.
- R3: Status bit 1 is the first enable stage and bit 2 the second. A status write loads bit1 into stage one and bit2 into stage two. A status write with bit 2 set is ignored unless bit 1 is also set and stage one is already set, so 0x02 followed by 0x06 unlocks.
- R4: Writing 0x00 to status clears both stages and re-locks the bank.
- R5: While either stage is clear, writes to 0x30..0x37 and 0x10 change nothing.
- R6: Status bit 7 reads `on_battery`, bit 0 reads `osc_fail`, bits 6:3 read 0. Writes cannot alter them.
- R7: The seconds field advances on the `TICKS_PER_SEC`-th tick. Seconds and minutes count BCD 00..59, and each wraps with a carry.
- R8: With hour bit 7 set, bits 5:0 count BCD 00..23, and the wrap from 23 carries into the date.
- R9: With hour bit 7 clear, bits 4:0 count BCD 12,01..11, and bit 5 is PM. 11 to 12 toggles PM, and only the PM-to-AM toggle carries into the date.
- R10: The date wraps to 01 after 31, 30 or 28 days as the month dictates. February has 29 days when the binary year within the century is divisible by 4.
- R11: Month wraps 12 to 01 and carries into the year. Year wraps 99 to 00 and carries into the century, which wraps 99 to 00.
- R12: Day of week counts 0..6 and advances once per date wrap.
- R13: A write to seconds clears the prescaler and cancels any second step in that cycle. Any other time write in a stepping cycle overrides only its own field, while the other fields still step.
- R14: While unlocked, control bits 7:3 store written data, and bits 2:0 read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| tick | input | 1 | Prescaler enable pulse |
| wr_en | input | 1 | Write strobe |
| rd_en | input | 1 | Read strobe |
| addr | input | 8 | Byte address |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data (combinational) |
| on_battery | input | 1 | Battery-power flag shown in status bit 7 |
| osc_fail | input | 1 | Oscillator-failure flag shown in status bit 0 |

## Verification
A software write to a time field and a prescaler-driven second step can land in the same clock edge. The bench forces this deliberately. It parks the prescaler one tick short of a step with seconds at 59, then writes minutes, or writes seconds, in the cycle that carries the final tick. The result is judged against R13: a minutes write must win over the carry while seconds still wrap to 00, and a seconds write must cancel the step and restart a full second. Random traffic then mixes writes and ticks freely, and every byte is compared to a bench model.

// File: rtl/rtc_pkg.sv
// Shared field indices, addresses, reset image and BCD helpers for the
// calendar register bank. Assumes all stored fields are packed BCD.
package rtc_pkg;
    localparam int NUM_FIELDS = 8;
    localparam int F_SEC  = 0;
    localparam int F_MIN  = 1;
    localparam int F_HOUR = 2;
    localparam int F_DATE = 3;
    localparam int F_MON  = 4;
    localparam int F_YEAR = 5;
    localparam int F_DOW  = 6;
    localparam int F_CENT = 7;

    localparam logic [7:0] ADDR_CTRL = 8'h10;
    localparam logic [7:0] ADDR_TIME = 8'h30;
    localparam logic [7:0] ADDR_STAT = 8'h3F;

    // Reset image, highest field first: century .. seconds
    localparam logic [NUM_FIELDS-1:0][7:0] CAL_RESET =
        {8'h20, 8'h00, 8'h00, 8'h01, 8'h01, 8'h80, 8'h00, 8'h00};

    // Add one to a two-digit BCD byte (no wrap handling)
    function automatic logic [7:0] bcd_inc(input logic [7:0] v);
        if (v[3:0] >= 4'd9) return {v[7:4] + 4'd1, 4'd0};
        return {v[7:4], v[3:0] + 4'd1};
    endfunction

    // Leap test on a BCD year: binary value divisible by four
    function automatic logic bcd_leap(input logic [7:0] yr);
        if (yr[4]) return (yr[3:0] == 4'd2) || (yr[3:0] == 4'd6);
        return (yr[3:0] == 4'd0) || (yr[3:0] == 4'd4) || (yr[3:0] == 4'd8);
    endfunction

    // Last day of a BCD month, as BCD
    function automatic logic [7:0] month_len(input logic [7:0] mon, input logic [7:0] yr);
        case (mon)
            8'h02:                      return bcd_leap(yr) ? 8'h29 : 8'h28;
            8'h04, 8'h06, 8'h09, 8'h11: return 8'h30;
            default:                    return 8'h31;
        endcase
    endfunction
endpackage

// File: rtl/rtc_lock.sv
// Two-stage write-enable latch. Stage one must already be set before a
// write can set stage two. Assumes wr_stat is a single-cycle strobe.
module rtc_lock (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       wr_stat,
    input  logic [2:1] wbits,
    output logic       wel,
    output logic       rwel
);
    logic accept;

    // A request for stage two is honoured only with stage one set and kept
    assign accept = wr_stat && (!wbits[2] || (wbits[1] && wel));

    // Latch both stages from an accepted status write
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wel  <= 1'b0;
            rwel <= 1'b0;
        end else if (accept) begin
            wel  <= wbits[1];
            rwel <= wbits[2];
        end
    end
endmodule

// File: rtl/rtc_counter.sv
// Prescaler plus BCD calendar chain. Field writes take priority over the
// step. A seconds write clears the prescaler and cancels the step.
// Assumes written values are valid BCD in their field ranges.
module rtc_counter
    import rtc_pkg::*;
#(
    parameter int TICKS_PER_SEC = 32768
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          tick,
    input  logic [NUM_FIELDS-1:0]         field_we,
    input  logic [7:0]                    wdata,
    output logic [NUM_FIELDS-1:0][7:0]    cal,
    output logic                          sec_step
);
    localparam int PW = (TICKS_PER_SEC > 1) ? $clog2(TICKS_PER_SEC) : 1;
    localparam logic [PW-1:0] PLAST = PW'(TICKS_PER_SEC - 1);

    logic [PW-1:0]                 presc;
    logic [NUM_FIELDS-1:0][7:0]    nxt;
    logic                          c_min, c_hr, c_day, c_mon, c_yr, pm;
    logic [7:0]                    h, t;

    assign sec_step = tick && (presc == PLAST) && !field_we[F_SEC];

    // Sub-second prescaler, restarted by a seconds write
    always_ff @(posedge clk) begin
        if (!rst_n)                presc <= '0;
        else if (field_we[F_SEC])  presc <= '0;
        else if (tick)             presc <= (presc == PLAST) ? '0 : presc + 1'b1;
    end

    // Next calendar value if one second elapses now
    always_comb begin
        nxt   = cal;
        c_hr  = 1'b0;
        c_day = 1'b0;
        c_mon = 1'b0;
        c_yr  = 1'b0;
        pm    = cal[F_HOUR][5];
        h     = cal[F_HOUR];
        t     = 8'h00;
        c_min = (cal[F_SEC] == 8'h59);
        nxt[F_SEC] = c_min ? 8'h00 : bcd_inc(cal[F_SEC]);
        if (c_min) begin
            c_hr = (cal[F_MIN] == 8'h59);
            nxt[F_MIN] = c_hr ? 8'h00 : bcd_inc(cal[F_MIN]);
        end
        if (c_hr) begin
            if (h[7]) begin
                if (h[5:0] == 6'h23) begin
                    h[5:0] = 6'h00;
                    c_day  = 1'b1;
                end else begin
                    t      = bcd_inc({2'b00, h[5:0]});
                    h[5:0] = t[5:0];
                end
            end else begin
                if (h[4:0] == 5'h12) begin
                    h[4:0] = 5'h01;
                end else if (h[4:0] == 5'h11) begin
                    h[4:0] = 5'h12;
                    c_day  = pm;
                    h[5]   = !pm;
                end else begin
                    t      = bcd_inc({3'b000, h[4:0]});
                    h[4:0] = t[4:0];
                end
            end
            nxt[F_HOUR] = h;
        end
        if (c_day) begin
            c_mon = (cal[F_DATE] == month_len(cal[F_MON], cal[F_YEAR]));
            nxt[F_DATE] = c_mon ? 8'h01 : bcd_inc(cal[F_DATE]);
            nxt[F_DOW]  = (cal[F_DOW] == 8'h06) ? 8'h00 : cal[F_DOW] + 8'h01;
        end
        if (c_mon) begin
            c_yr = (cal[F_MON] == 8'h12);
            nxt[F_MON] = c_yr ? 8'h01 : bcd_inc(cal[F_MON]);
        end
        if (c_yr) begin
            nxt[F_YEAR] = (cal[F_YEAR] == 8'h99) ? 8'h00 : bcd_inc(cal[F_YEAR]);
            if (cal[F_YEAR] == 8'h99)
                nxt[F_CENT] = (cal[F_CENT] == 8'h99) ? 8'h00 : bcd_inc(cal[F_CENT]);
        end
    end

    // Field registers: write first, then the one-second step
    always_ff @(posedge clk) begin
        for (int i = 0; i < NUM_FIELDS; i++) begin
            if (!rst_n)            cal[i] <= CAL_RESET[i];
            else if (field_we[i])  cal[i] <= wdata;
            else if (sec_step)     cal[i] <= nxt[i];
        end
    end
endmodule

// File: rtl/rtc_regbank.sv
// Byte-addressed calendar register bank: decode, write gating, control
// byte and combinational read mux. Assumes strobes last one cycle each.
module rtc_regbank
    import rtc_pkg::*;
#(
    parameter int TICKS_PER_SEC = 32768
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       tick,
    input  logic       wr_en,
    input  logic       rd_en,
    input  logic [7:0] addr,
    input  logic [7:0] wdata,
    output logic [7:0] rdata,
    input  logic       on_battery,
    input  logic       osc_fail
);
    logic                        wel, rwel, unlocked, sec_step;
    logic [NUM_FIELDS-1:0]       field_we;
    logic [NUM_FIELDS-1:0][7:0]  cal;
    logic [4:0]                  ctrl_q;
    logic [7:0]                  rd_val;

    assign unlocked = wel && rwel;

    rtc_lock u_lock (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_stat (wr_en && (addr == ADDR_STAT)),
        .wbits   (wdata[2:1]),
        .wel     (wel),
        .rwel    (rwel)
    );

    // One gated write enable per time field
    for (genvar g = 0; g < NUM_FIELDS; g++) begin : g_we
        assign field_we[g] = wr_en && unlocked && (addr == ADDR_TIME + 8'(g));
    end

    rtc_counter #(.TICKS_PER_SEC(TICKS_PER_SEC)) u_cnt (
        .clk      (clk),
        .rst_n    (rst_n),
        .tick     (tick),
        .field_we (field_we),
        .wdata    (wdata),
        .cal      (cal),
        .sec_step (sec_step)
    );

    // Control byte: plain storage of the upper five bits when unlocked
    always_ff @(posedge clk) begin
        if (!rst_n)                                    ctrl_q <= '0;
        else if (wr_en && unlocked && addr == ADDR_CTRL) ctrl_q <= wdata[7:3];
    end

    // Address decode for reads
    always_comb begin
        rd_val = 8'h00;
        if (addr[7:3] == ADDR_TIME[7:3])  rd_val = cal[addr[2:0]];
        else if (addr == ADDR_CTRL)       rd_val = {ctrl_q, 3'b000};
        else if (addr == ADDR_STAT)       rd_val = {on_battery, 4'b0000, rwel, wel, osc_fail};
    end

    assign rdata = rd_en ? rd_val : 8'h00;
endmodule

// File: rtl/rtc_regbank_chk.sv
// Property checker for the calendar register bank, attached by bind.
module rtc_regbank_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       wr_en,
    input logic [7:0] addr,
    input logic [7:0] wdata,
    input logic       wel,
    input logic       rwel,
    input logic [4:0] ctrl_q,
    input logic [7:0] sec_q,
    input logic       sec_step
);
    // R3
    stage_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rwel |-> wel);
    // R3
    early_stage2_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && addr == 8'h3F && wdata[2] && !wel) |=> (!wel && !rwel));
    // R4
    relock_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && addr == 8'h3F && wdata[2:1] == 2'b00) |=> (!wel && !rwel));
    // R5
    locked_ctrl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && addr == 8'h10 && !(wel && rwel)) |=> $stable(ctrl_q));
    // R14
    ctrl_store_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && addr == 8'h10 && wel && rwel) |=> (ctrl_q == $past(wdata[7:3])));
    // R7
    sec_moves_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sec_step |=> (sec_q != $past(sec_q)));
    // R13
    sec_write_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && addr == 8'h30 && wel && rwel) |=> (sec_q == $past(wdata)));
endmodule

bind rtc_regbank rtc_regbank_chk u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_en    (wr_en),
    .addr     (addr),
    .wdata    (wdata),
    .wel      (wel),
    .rwel     (rwel),
    .ctrl_q   (ctrl_q),
    .sec_q    (cal[0]),
    .sec_step (sec_step)
);

// File: tb/rtc_regbank_bench.sv
module rtc_regbank_bench;
    localparam int TPS = 4;

    logic clk = 1'b0, rst_n = 1'b0, tick = 1'b0, wr_en = 1'b0, rd_en = 1'b0;
    logic on_battery = 1'b0, osc_fail = 1'b0;
    logic [7:0] addr = 8'h00, wdata = 8'h00;
    logic [7:0] rdata;

    always #10 clk = ~clk;

    rtc_regbank #(.TICKS_PER_SEC(TPS)) u_rtc_regbank (
        .clk(clk), .rst_n(rst_n), .tick(tick), .wr_en(wr_en), .rd_en(rd_en),
        .addr(addr), .wdata(wdata), .rdata(rdata),
        .on_battery(on_battery), .osc_fail(osc_fail)
    );

    int  n_cmp = 0, n_bad = 0;
    bit  done = 1'b0;
    logic [7:0] m [8];
    logic [7:0] mctrl;
    logic mwel, mrwel;
    int  mcnt;

    function automatic int b2i(input logic [7:0] v);
        return int'(v[7:4]) * 10 + int'(v[3:0]);
    endfunction
    function automatic logic [7:0] i2b(input int n);
        return 8'(((n / 10) << 4) + (n % 10));
    endfunction
    function automatic int mdays(input logic [7:0] mon, input logic [7:0] yr);
        case (b2i(mon))
            2:           return (b2i(yr) % 4 == 0) ? 29 : 28;
            4, 6, 9, 11: return 30;
            default:     return 31;
        endcase
    endfunction

    // Reference model of one clock edge
    task automatic model_step(input bit w, input logic [7:0] a, input logic [7:0] d, input bit tk);
        logic [7:0] n [8];
        logic [7:0] t;
        bit unl, c, pm;
        int hb;
        n = m;
        unl = mwel && mrwel;
        if (w && unl && a == 8'h30) mcnt = 0;
        else if (tk) begin
            if (mcnt == TPS - 1) begin
                mcnt = 0;
                c = (n[0] == 8'h59); n[0] = c ? 8'h00 : i2b(b2i(n[0]) + 1);
                if (c) begin c = (n[1] == 8'h59); n[1] = c ? 8'h00 : i2b(b2i(n[1]) + 1); end
                if (c) begin
                    if (n[2][7]) begin
                        hb = b2i({2'b00, n[2][5:0]}); c = (hb == 23); hb = c ? 0 : hb + 1;
                        t = i2b(hb); n[2] = {n[2][7:6], t[5:0]};
                    end else begin
                        hb = b2i({3'b000, n[2][4:0]}); pm = n[2][5]; c = 1'b0;
                        if (hb == 11) begin hb = 12; c = pm; pm = !pm; end
                        else if (hb == 12) hb = 1;
                        else hb = hb + 1;
                        t = i2b(hb); n[2] = {n[2][7:6], pm, t[4:0]};
                    end
                end
                if (c) begin
                    c = (b2i(n[3]) == mdays(n[4], n[5]));
                    n[3] = c ? 8'h01 : i2b(b2i(n[3]) + 1);
                    n[6] = (n[6] == 8'h06) ? 8'h00 : n[6] + 8'h01;
                end
                if (c) begin c = (n[4] == 8'h12); n[4] = c ? 8'h01 : i2b(b2i(n[4]) + 1); end
                if (c) begin c = (n[5] == 8'h99); n[5] = c ? 8'h00 : i2b(b2i(n[5]) + 1); end
                if (c) n[7] = (n[7] == 8'h99) ? 8'h00 : i2b(b2i(n[7]) + 1);
            end else mcnt = mcnt + 1;
        end
        if (w) begin
            if (a == 8'h3F) begin
                if (!d[2] || (d[1] && mwel)) begin mwel = d[1]; mrwel = d[2]; end
            end else if (unl && a == 8'h10) mctrl = d & 8'hF8;
            else if (unl && a >= 8'h30 && a <= 8'h37) n[a - 8'h30] = d;
        end
        m = n;
    endtask

    function automatic logic [7:0] model_reg(input logic [7:0] a);
        if (a >= 8'h30 && a <= 8'h37) return m[a - 8'h30];
        if (a == 8'h10) return mctrl;
        if (a == 8'h3F) return {on_battery, 4'b0000, mrwel, mwel, osc_fail};
        return 8'h00;
    endfunction

    task automatic chk(input string tag, input logic [7:0] got, input logic [7:0] exp);
        n_cmp++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", tag, got, exp);
        end
    endtask

    task automatic cyc(input bit w, input logic [7:0] a, input logic [7:0] d, input bit tk);
        @(negedge clk);
        wr_en = w; addr = a; wdata = d; tick = tk; rd_en = 1'b0;
        model_step(w, a, d, tk);
    endtask

    task automatic ticks(input int k);
        for (int i = 0; i < k; i++) cyc(1'b0, 8'h00, 8'h00, 1'b1);
    endtask

    task automatic expect_reg(input string tag, input logic [7:0] a, input logic [7:0] exp);
        @(negedge clk);
        wr_en = 1'b0; tick = 1'b0; rd_en = 1'b1; addr = a;
        #1 chk(tag, rdata, exp);
        rd_en = 1'b0;
    endtask

    task automatic check_all(input string tag);
        for (int i = 0; i < 8; i++) expect_reg(tag, 8'h30 + 8'(i), model_reg(8'h30 + 8'(i)));
        expect_reg(tag, 8'h10, model_reg(8'h10));
        expect_reg(tag, 8'h3F, model_reg(8'h3F));
    endtask

    // Load a full time image; seconds last so the prescaler restarts
    task automatic set_time(input logic [7:0] hr, input logic [7:0] dt, input logic [7:0] mo,
                            input logic [7:0] yr, input logic [7:0] cen);
        cyc(1'b1, 8'h32, hr, 1'b0);  cyc(1'b1, 8'h33, dt, 1'b0);
        cyc(1'b1, 8'h34, mo, 1'b0);  cyc(1'b1, 8'h35, yr, 1'b0);
        cyc(1'b1, 8'h37, cen, 1'b0); cyc(1'b1, 8'h31, 8'h59, 1'b0);
        cyc(1'b1, 8'h30, 8'h59, 1'b0);
    endtask

    function automatic logic [7:0] rand_val(input int idx);
        case (idx)
            0, 1: return i2b($urandom % 60);
            2:    if ($urandom % 2) return 8'h80 | i2b($urandom % 24);
                  else return {2'b00, 1'($urandom % 2), 5'(i2b(1 + $urandom % 12))};
            3:    return i2b(1 + $urandom % 28);
            4:    return i2b(1 + $urandom % 12);
            6:    return 8'($urandom % 7);
            default: return i2b($urandom % 100);
        endcase
    endfunction

    task automatic finish_run();
        done = 1'b1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    endtask

    initial begin
        #(20 * 150000);
        if (!done) begin
            n_cmp++; n_bad++;
            $display("FAIL watchdog: actual hung expected completion");
            finish_run();
        end
    end

    initial begin
        logic [7:0] sv [5];
        void'($urandom(32'd4242));
        m[0] = 8'h00; m[1] = 8'h00; m[2] = 8'h80; m[3] = 8'h01;
        m[4] = 8'h01; m[5] = 8'h00; m[6] = 8'h00; m[7] = 8'h20;
        mctrl = 8'h00; mwel = 1'b0; mrwel = 1'b0; mcnt = 0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1 reset image
        expect_reg("R1 seconds", 8'h30, 8'h00);
        expect_reg("R1 hour",    8'h32, 8'h80);
        expect_reg("R1 date",    8'h33, 8'h01);
        expect_reg("R1 month",   8'h34, 8'h01);
        expect_reg("R1 century", 8'h37, 8'h20);
        expect_reg("R1 status",  8'h3F, 8'h00);
        // R2 strobe gating and unmapped address
        @(negedge clk); rd_en = 1'b0; addr = 8'h37; #1 chk("R2 rd_en low", rdata, 8'h00);
        expect_reg("R2 unmapped", 8'h20, 8'h00);
        // R6 live flags, not writable
        on_battery = 1'b1; osc_fail = 1'b1;
        expect_reg("R6 flags", 8'h3F, 8'h81);
        cyc(1'b1, 8'h3F, 8'h7E, 1'b0);
        expect_reg("R6 flags after write", 8'h3F, 8'h81);
        on_battery = 1'b0; osc_fail = 1'b0;
        // R5 locked writes
        cyc(1'b1, 8'h31, 8'h45, 1'b0);
        expect_reg("R5 minutes locked", 8'h31, 8'h00);
        cyc(1'b1, 8'h10, 8'hE8, 1'b0);
        expect_reg("R5 control locked", 8'h10, 8'h00);
        // R3 unlock sequence
        cyc(1'b1, 8'h3F, 8'h06, 1'b0);
        expect_reg("R3 early stage two", 8'h3F, 8'h00);
        cyc(1'b1, 8'h3F, 8'h02, 1'b0);
        expect_reg("R3 stage one", 8'h3F, 8'h02);
        cyc(1'b1, 8'h3F, 8'h06, 1'b0);
        expect_reg("R3 unlocked", 8'h3F, 8'h06);
        // R14 control storage
        cyc(1'b1, 8'h10, 8'hFF, 1'b0);
        expect_reg("R14 control", 8'h10, 8'hF8);
        // R8 R10 R12 leap February
        cyc(1'b1, 8'h36, 8'h06, 1'b0);
        set_time(8'hA3, 8'h28, 8'h02, 8'h24, 8'h20);
        ticks(3);
        expect_reg("R7 no step before limit", 8'h30, 8'h59);
        ticks(1);
        expect_reg("R7 seconds wrap", 8'h30, 8'h00);
        expect_reg("R8 hour wrap",    8'h32, 8'h80);
        expect_reg("R10 leap day",    8'h33, 8'h29);
        expect_reg("R12 dow wrap",    8'h36, 8'h00);
        // R10 common year
        set_time(8'hA3, 8'h28, 8'h02, 8'h23, 8'h20);
        ticks(4);
        expect_reg("R10 common date", 8'h33, 8'h01);
        expect_reg("R10 common month", 8'h34, 8'h03);
        // R11 century wrap
        set_time(8'hA3, 8'h31, 8'h12, 8'h99, 8'h20);
        ticks(4);
        expect_reg("R11 month",   8'h34, 8'h01);
        expect_reg("R11 year",    8'h35, 8'h00);
        expect_reg("R11 century", 8'h37, 8'h21);
        // R9 twelve-hour
        set_time(8'h11, 8'h05, 8'h01, 8'h10, 8'h20);
        ticks(4);
        expect_reg("R9 noon", 8'h32, 8'h32);
        expect_reg("R9 no date carry", 8'h33, 8'h05);
        set_time(8'h31, 8'h05, 8'h01, 8'h10, 8'h20);
        ticks(4);
        expect_reg("R9 midnight", 8'h32, 8'h12);
        expect_reg("R9 date carry", 8'h33, 8'h06);
        set_time(8'h12, 8'h05, 8'h01, 8'h10, 8'h20);
        ticks(4);
        expect_reg("R9 twelve to one", 8'h32, 8'h01);
        // R13 same-cycle collisions
        cyc(1'b1, 8'h31, 8'h10, 1'b0);
        cyc(1'b1, 8'h30, 8'h59, 1'b0);
        ticks(3);
        cyc(1'b1, 8'h31, 8'h40, 1'b1);
        expect_reg("R13 minutes write wins", 8'h31, 8'h40);
        expect_reg("R13 seconds still step", 8'h30, 8'h00);
        ticks(3);
        cyc(1'b1, 8'h30, 8'h20, 1'b1);
        expect_reg("R13 seconds write wins", 8'h30, 8'h20);
        ticks(3);
        expect_reg("R13 full second pending", 8'h30, 8'h20);
        ticks(1);
        expect_reg("R13 full second done", 8'h30, 8'h21);
        // R4 relock
        cyc(1'b1, 8'h3F, 8'h00, 1'b0);
        expect_reg("R4 status", 8'h3F, 8'h00);
        for (int i = 0; i < 5; i++) sv[i] = m[i];
        cyc(1'b1, 8'h30, 8'h05, 1'b0);
        expect_reg("R4 write ignored", 8'h30, sv[0]);

        // Random mix of writes, lock traffic and ticks
        cyc(1'b1, 8'h3F, 8'h02, 1'b0);
        cyc(1'b1, 8'h3F, 8'h06, 1'b0);
        for (int it = 0; it < 6000; it++) begin
            int r, f;
            r = $urandom % 100;
            if (r < 8) begin
                f = $urandom % 8;
                cyc(1'b1, 8'h30 + 8'(f), rand_val(f), ($urandom % 2) == 1);
            end else if (r < 10) begin
                case ($urandom % 5)
                    0: cyc(1'b1, 8'h3F, 8'h00, 1'b0);
                    1: cyc(1'b1, 8'h3F, 8'h04, 1'b0);
                    2: cyc(1'b1, 8'h3F, 8'h02, 1'b0);
                    default: cyc(1'b1, 8'h3F, 8'h06, 1'b0);
                endcase
            end else if (r < 11) cyc(1'b1, 8'h10, 8'($urandom), 1'b1);
            else if (r < 12) on_battery = ~on_battery;
            else if (r < 85) cyc(1'b0, 8'h00, 8'h00, 1'b1);
            else cyc(1'b0, 8'h00, 8'h00, 1'b0);
            if (it % 300 == 299) check_all("R2 R7 R13 random model");
        end
        check_all("R11 R12 final model");
        finish_run();
    end
endmodule